// File: doc/BRIEF.md
# Tick Counter Bank With Compare Interrupts

The block holds three free-running cycle counters that share one register port. They serve as the processor tick, the system tick and the hypervisor tick. Each counter has a 64-bit compare register. The top bit of that register masks the compare interrupt, and the lower 63 bits hold the compare value. When a counter equals its compare value and the mask is clear, the block sends a one-cycle timer interrupt request. The processor tick and the system tick also latch a bit in a soft-interrupt output. The hypervisor tick only requests the interrupt.

Software writes a count or a compare value through a single write port: it picks a timer and chooses count or compare. Software reads any count or compare value through a read port that returns data one cycle later. A clear strobe per soft-interrupt bit lets the interrupt handler drop a latched bit.

Top module: `tickcmp_timers`

## Requirements
- R1: After reset, every compare register reads 0x8000_0000_0000_0000 (masked, value zero). Every count starts at zero, and `soft_int` and `timer_irq` are 0.
- R2: Each count advances by one on every clock. A read selected in cycle m returns, in cycle m+1, the count held during cycle m. Bit 63 of a count read is always 0.
- R3: A count wraps from 0x7FFF_FFFF_FFFF_FFFF to 0.
- R4: A count write takes effect at the next clock edge with bits 62:0 of `wr_data`, and the count then keeps running from that value. Bit 63 of the written data is dropped.
- R5: A compare write stores all 64 bits of `wr_data`, and a compare read returns them.
- R6: When the processor-tick count (timer 0) equals bits 62:0 of its compare value and compare bit 63 is 0, `soft_int[0]` sets and `timer_irq` pulses for exactly one cycle. Both take effect at the clock edge that ends the equal cycle.
- R7: The same kind of match on the system tick (timer 1) sets `soft_int[1]` and pulses `timer_irq`.
- R8: A match on the hypervisor tick (timer 2) pulses `timer_irq` and leaves `soft_int` unchanged.
- R9: While compare bit 63 is 1, a match changes neither `timer_irq` nor `soft_int`.
- R10: A soft-interrupt bit stays set until its `soft_clr` bit is pulsed. When a set and a clear of the same bit meet in one cycle, the bit ends up set.
- R11: An equality that lasts several cycles, for example because the count is written with the same value again and again, gives one pulse. A later new equality, or a compare write, arms the detection again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Timer written: 0 processor tick, 1 system tick, 2 hypervisor tick |
| wr_cmp | input | 1 | 1 writes the compare register, 0 writes the count |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Timer read, same encoding as `wr_sel` |
| rd_cmp | input | 1 | 1 reads the compare register, 0 reads the count |
| rd_data | output | 64 | Registered read data, valid one cycle after the select |
| soft_clr | input | 2 | Clear strobes for the soft-interrupt bits |
| soft_int | output | 2 | Soft-interrupt bits: bit 0 processor tick, bit 1 system tick |
| timer_irq | output | 1 | One-cycle timer interrupt request |

## Verification
The assertions assume a single write port, so one cycle updates at most one register, and they assume that `wr_sel` and `rd_sel` never select the unused code 3. They also assume that reset is held for at least one edge before any check counts. The stimulus drives every strobe for exactly one clock, except the deliberate repeated count writes that test R11. It uses only timer codes 0 to 2, and it places compare values far from the running counts so that no match fires outside the window a test sets up.

// File: rtl/tickcmp_pkg.sv
package tickcmp_pkg;
  localparam int unsigned N_TMR  = 3;
  localparam int unsigned N_SOFT = 2;
  localparam int unsigned TMR_PROC = 0;
  localparam int unsigned TMR_SYS  = 1;
  localparam int unsigned TMR_HYP  = 2;

  // soft-interrupt bit driven by a timer, -1 for none
  function automatic int soft_bit_of(input int unsigned tmr);
    case (tmr)
      TMR_PROC: soft_bit_of = 0;
      TMR_SYS:  soft_bit_of = 1;
      default:  soft_bit_of = -1;
    endcase
  endfunction
endpackage

// File: rtl/tickcmp_unit.sv
module tickcmp_unit #(
  parameter int unsigned W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_wr,
  input  logic           cmp_wr,
  input  logic [W-1:0]   wdata,
  output logic [W-2:0]   cnt_o,
  output logic [W-1:0]   cmp_o,
  output logic           hit_o
);
  localparam int unsigned CW = W - 1;
  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [W-1:0]  CMP_RESET = {1'b1, {CW{1'b0}}};

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  cmp_q;
  logic          seen_q;
  logic          equal;

  assign equal = (cnt_q == cmp_q[CW-1:0]);
  assign hit_o = equal & ~seen_q & ~cmp_q[W-1];
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmp_q  <= CMP_RESET;
      seen_q <= 1'b0;
    end else begin
      if (cnt_wr) cnt_q <= wdata[CW-1:0];
      else        cnt_q <= cnt_q + ONE;
      if (cmp_wr) cmp_q <= wdata;
      seen_q <= equal & ~cmp_wr;
    end
  end

  a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> cnt_q == $past(cnt_q) + ONE);
  a_r4_count_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_q == $past(wdata[CW-1:0]));
  a_r5_cmp_load: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> cmp_q == $past(wdata));
  a_r11_one_shot: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !cmp_wr) |=> !hit_o);
endmodule

// File: rtl/tickcmp_soft.sv
module tickcmp_soft #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] soft_o
);
  logic [N-1:0] soft_q;

  always_ff @(posedge clk) begin
    if (rst) soft_q <= '0;
    else     soft_q <= (soft_q & ~clr_i) | set_i;
  end

  assign soft_o = soft_q;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((soft_q & $past(set_i)) == $past(set_i)));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(soft_q));
endmodule

// File: rtl/tickcmp_rdmux.sv
module tickcmp_rdmux #(
  parameter int unsigned W  = 64,
  parameter int unsigned N  = 3,
  parameter int unsigned SW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0][W-2:0]  cnt_i,
  input  logic [N-1:0][W-1:0]  cmp_i,
  input  logic [SW-1:0]        sel_i,
  input  logic                 is_cmp_i,
  output logic [W-1:0]         rd_o
);
  logic [W-1:0] rd_next;
  logic [W-1:0] rd_q;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SW'(i)) rd_next = is_cmp_i ? cmp_i[i] : {1'b0, cnt_i[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_o = rd_q;

  a_r2_count_msb_zero: assert property (@(posedge clk) disable iff (rst)
    !is_cmp_i |=> rd_q[W-1] == 1'b0);
endmodule

// File: rtl/tickcmp_timers.sv
module tickcmp_timers
  import tickcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned SEL_W = $clog2(N_TMR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_cmp,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic              rd_cmp,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [N_SOFT-1:0] soft_clr,
  output logic [N_SOFT-1:0] soft_int,
  output logic              timer_irq
);
  logic [N_TMR-1:0]            hits;
  logic [N_TMR-1:0][CNT_W-2:0] cnts;
  logic [N_TMR-1:0][CNT_W-1:0] cmps;
  logic [N_SOFT-1:0]           soft_set;
  logic                        irq_q;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic sel_me;
    assign sel_me = wr_en && (wr_sel == SEL_W'(i));

    tickcmp_unit #(.W(CNT_W)) u_unit (
      .clk    (clk),
      .rst    (rst),
      .cnt_wr (sel_me && !wr_cmp),
      .cmp_wr (sel_me && wr_cmp),
      .wdata  (wr_data),
      .cnt_o  (cnts[i]),
      .cmp_o  (cmps[i]),
      .hit_o  (hits[i])
    );

    if (soft_bit_of(i) >= 0) begin : g_soft
      assign soft_set[soft_bit_of(i)] = hits[i];
    end
  end

  tickcmp_soft #(.N(N_SOFT)) u_soft (
    .clk    (clk),
    .rst    (rst),
    .set_i  (soft_set),
    .clr_i  (soft_clr),
    .soft_o (soft_int)
  );

  tickcmp_rdmux #(.W(CNT_W), .N(N_TMR), .SW(SEL_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (cnts),
    .cmp_i    (cmps),
    .sel_i    (rd_sel),
    .is_cmp_i (rd_cmp),
    .rd_o     (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |hits;
  end

  assign timer_irq = irq_q;

  a_r6_irq_after_hit: assert property (@(posedge clk) disable iff (rst)
    (|hits) |=> timer_irq);
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    !(|hits) |=> !timer_irq);
  a_r8_hyp_no_soft: assert property (@(posedge clk) disable iff (rst)
    (hits[TMR_HYP] && !(|hits[N_SOFT-1:0]) && soft_clr == '0) |=> $stable(soft_int));
endmodule

// File: tb/tickcmp_timers_bench.sv
module tickcmp_timers_bench;
  localparam logic [63:0] MASK63 = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] CMP_RST = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic        wr_cmp = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic        rd_cmp = 1'b0;
  logic [63:0] rd_data;
  logic [1:0]  soft_clr = 2'b00;
  logic [1:0]  soft_int;
  logic        timer_irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  int          due_q[$];
  logic [63:0] exp_q[$];
  string       req_q[$];

  always #10 clk = ~clk;

  tickcmp_timers u_tickcmp_timers (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_cmp(wr_cmp),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_cmp(rd_cmp), .rd_data(rd_data),
    .soft_clr(soft_clr), .soft_int(soft_int), .timer_irq(timer_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && timer_irq) irq_seen = irq_seen + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected reads when they come due
  always @(negedge clk) begin
    #2;
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      check(req_q[0], rd_data, exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(req_q.pop_front());
    end
  end

  task automatic issue_rd(input logic [1:0] t, input bit c, input logic [63:0] e, input string r);
    rd_sel = t;
    rd_cmp = c;
    due_q.push_back(cyc + 1);
    exp_q.push_back(e);
    req_q.push_back(r);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] t, input bit c, input logic [63:0] d);
    wr_en = 1'b1; wr_sel = t; wr_cmp = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    soft_clr = m;
    @(negedge clk);
    soft_clr = 2'b00;
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    int b;
    int n0;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    b = cyc;
    // R1 reset state
    check("R1 soft_int", {62'd0, soft_int}, 64'd0);
    check("R1 timer_irq", {63'd0, timer_irq}, 64'd0);
    issue_rd(2'd0, 1'b0, 64'd0, "R1 tick count");
    issue_rd(2'd1, 1'b0, 64'(cyc - b), "R2 sys count running");
    issue_rd(2'd2, 1'b0, 64'(cyc - b), "R2 hyp count running");
    issue_rd(2'd0, 1'b1, CMP_RST, "R1 tick compare");
    issue_rd(2'd1, 1'b1, CMP_RST, "R1 sys compare");
    issue_rd(2'd2, 1'b1, CMP_RST, "R1 hyp compare");

    // R4 count write drops bit 63, R2 keeps running
    v = 64'hFFFF_0000_0000_1234;
    wr_reg(2'd0, 1'b0, v);
    b = cyc;
    issue_rd(2'd0, 1'b0, v & MASK63, "R4 count load");
    repeat (4) @(negedge clk);
    issue_rd(2'd0, 1'b0, (v + 64'(cyc - b)) & MASK63, "R2 count after idle");

    // R3 wrap
    v = 64'h7FFF_FFFF_FFFF_FFFE;
    wr_reg(2'd1, 1'b0, v);
    b = cyc;
    @(negedge clk);
    issue_rd(2'd1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, "R3 at limit");
    issue_rd(2'd1, 1'b0, 64'd0, "R3 wrapped");

    // R5 compare full width
    wr_reg(2'd2, 1'b1, 64'h0123_4567_89AB_CDEF);
    issue_rd(2'd2, 1'b1, 64'h0123_4567_89AB_CDEF, "R5 compare readback");
    wr_reg(2'd0, 1'b1, 64'hC000_0000_0000_0007);
    issue_rd(2'd0, 1'b1, 64'hC000_0000_0000_0007, "R5 compare bit63 kept");
    @(negedge clk);

    // R6 processor tick match
    wr_reg(2'd0, 1'b1, 64'd1000);
    wr_reg(2'd0, 1'b0, 64'd997);
    b = cyc;
    wait_until(b + 3);
    check("R6 no irq before match", {63'd0, timer_irq}, 64'd0);
    wait_until(b + 4);
    check("R6 irq on match", {63'd0, timer_irq}, 64'd1);
    check("R6 soft bit0 set", {62'd0, soft_int}, 64'd1);
    wait_until(b + 5);
    check("R6 irq one cycle", {63'd0, timer_irq}, 64'd0);

    // R10 hold then clear
    repeat (8) @(negedge clk);
    check("R10 soft held", {62'd0, soft_int}, 64'd1);
    pulse_clr(2'b01);
    check("R10 soft cleared", {62'd0, soft_int}, 64'd0);

    // R7 system tick match
    wr_reg(2'd1, 1'b1, 64'd2000);
    wr_reg(2'd1, 1'b0, 64'd1997);
    b = cyc;
    wait_until(b + 4);
    check("R7 irq on sys match", {63'd0, timer_irq}, 64'd1);
    check("R7 soft bit1 set", {62'd0, soft_int}, 64'd2);
    pulse_clr(2'b10);

    // R10 set beats clear
    wr_reg(2'd0, 1'b1, 64'd3000);
    wr_reg(2'd0, 1'b0, 64'd2997);
    b = cyc;
    wait_until(b + 3);
    soft_clr = 2'b01;
    @(negedge clk);
    soft_clr = 2'b00;
    check("R10 set wins over clear", {62'd0, soft_int}, 64'd1);
    pulse_clr(2'b01);
    check("R10 later clear works", {62'd0, soft_int}, 64'd0);

    // R8 hypervisor tick match
    wr_reg(2'd2, 1'b1, 64'd4000);
    wr_reg(2'd2, 1'b0, 64'd3997);
    b = cyc;
    wait_until(b + 4);
    check("R8 irq on hyp match", {63'd0, timer_irq}, 64'd1);
    check("R8 soft untouched", {62'd0, soft_int}, 64'd0);

    // R9 masked compare
    @(negedge clk);
    n0 = irq_seen;
    wr_reg(2'd0, 1'b1, 64'h8000_0000_0000_1388);
    wr_reg(2'd0, 1'b0, 64'd4997);
    b = cyc;
    wait_until(b + 6);
    check("R9 no irq when masked", 64'(irq_seen - n0), 64'd0);
    check("R9 no soft when masked", {62'd0, soft_int}, 64'd0);

    // R11 sustained equality fires once, new equality fires again
    wr_reg(2'd0, 1'b1, 64'd6000);
    n0 = irq_seen;
    wr_en = 1'b1; wr_sel = 2'd0; wr_cmp = 1'b0; wr_data = 64'd6000;
    repeat (5) @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 one pulse for held equality", 64'(irq_seen - n0), 64'd1);
    pulse_clr(2'b01);
    wr_reg(2'd0, 1'b0, 64'd5998);
    b = cyc;
    wait_until(b + 4);
    check("R11 new equality fires", 64'(irq_seen - n0), 64'd2);

    repeat (3) @(negedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule